// File: doc/BRIEF.md
# Quadrant Memory Bank Controller

This block sits between a 20-bit physical address and a set of static memory chips. It drives the chip selects, output enables and write enables of those chips directly. The 1M physical space is split into four 256K quadrants. Each quadrant has its own write-only 8-bit setting. That setting picks the chip select, the strobe pair, the number of added wait states, write protection, and an inversion of the two top address lines that is applied on the way out.

A request is accepted while the block is idle. The block captures the address, the direction and the setting of the quadrant it addresses. It then runs a read of 2 clocks or a write of 3 clocks, plus any wait states. In the last clock of the cycle it raises `done` for one clock. A separate input can hold chip select 1 low at all times, so that the memory on that select is gated only by its strobes.

Top module: `quad_bank_ctrl`

## Requirements
- R1: The setting that controls an access is the one written with `cfg_idx` equal to `req_addr[19:18]`. The settings of the other quadrants have no effect on that access.
- R2: Setting bits [1:0] select the chip select. Values 0, 1 and 2 drive `mem_cs_n[0]`, `[1]` and `[2]` low for every clock of the cycle. Value 3 drives none, and the cycle still runs with normal timing.
- R3: Setting bit 2 selects the strobe pair. 0 uses `mem_oe_n[0]`/`mem_we_n[0]` and 1 uses `mem_oe_n[1]`/`mem_we_n[1]`. The unused pair stays high.
- R4: A read lasts 2 clocks plus the wait count in setting bits [7:6]. The chosen `mem_oe_n` is low in every clock of the read, and no write enable goes low.
- R5: A write lasts 3 clocks plus the wait count. The chosen `mem_we_n` is low in every clock except the first and the last, and the address is stable while it is low. No output enable goes low during a write.
- R6: Setting bit 3 suppresses the write-enable pulse for writes to that quadrant. Cycle length and chip select are unchanged.
- R7: Setting bit 5 inverts `mem_addr[19]` and bit 4 inverts `mem_addr[18]`. All other address bits pass unchanged. The inversion never changes which quadrant's setting is used.
- R8: After reset all four settings are zero, and the outputs are idle: chip selects high (except under R9), strobes high, `done` low and `mem_addr` zero.
- R9: While `cs1_force` is high, `mem_cs_n[1]` is low, both in idle and during any access.
- R10: `done` is high only in the final clock of a cycle, for exactly one clock. A request presented while a cycle is running is ignored, and the running cycle's address is kept.
- R11: A setting write changes only the quadrant named by `cfg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a quadrant setting |
| cfg_idx | input | 2 | Quadrant number of the setting written |
| cfg_wdata | input | 8 | Setting value |
| cs1_force | input | 1 | Hold chip select 1 asserted permanently |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Physical address of the access |
| mem_addr | output | 20 | Address to the memory chips, after inversion |
| mem_cs_n | output | 3 | Active-low chip selects |
| mem_oe_n | output | 2 | Active-low output enables, one per strobe pair |
| mem_we_n | output | 2 | Active-low write enables, one per strobe pair |
| done | output | 1 | Final clock of the access cycle |

## Verification
Accesses are issued to every quadrant. For each access, the other three quadrants hold the bitwise complement of the setting in use, so reading from the wrong quadrant changes the chip select, the strobe pair or the length and shows up. The accesses cover reads and writes with zero, one and three wait states. Each one is checked clock by clock: a one-clock error in the strobe window or in the length shows up against the per-clock pin image. Directed cases cover:
- the reset values of the settings;
- the "no chip select" code;
- write inhibit, checked against the unchanged cycle length;
- inversion of A19 and A18 on addresses at quadrant edges;
- forced chip select 1;
- a request changed in the middle of a cycle.

// File: rtl/qbc_pkg.sv
package qbc_pkg;

  // Bit order of the setting byte: [7:6] waits, [5] invert A19,
  // [4] invert A18, [3] write block, [2] strobe pair, [1:0] chip select.
  typedef struct packed {
    logic [1:0] waits;
    logic       inv_top;
    logic       inv_next;
    logic       wr_block;
    logic       strobe_sel;
    logic [1:0] cs_sel;
  } bank_cfg_t;

  localparam int unsigned CFG_W = $bits(bank_cfg_t);

endpackage

// File: rtl/qbc_bank_regs.sv
module qbc_bank_regs
  import qbc_pkg::*;
#(
  parameter int unsigned NUM_Q = 4,
  localparam int unsigned IDX_W = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output bank_cfg_t        cfg_o [NUM_Q]
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_bank
    logic      hit;
    bank_cfg_t cfg_q;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q <= '0;
      else if (hit) cfg_q <= bank_cfg_t'(wr_data_i);
    end

    assign cfg_o[q] = cfg_q;
  end

endmodule

// File: rtl/qbc_cycle_seq.sv
module qbc_cycle_seq
  import qbc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned RD_BASE = 2,
  parameter int unsigned WR_BASE = 3,
  localparam int unsigned MAX_LEN = WR_BASE + 3,
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  bank_cfg_t         sel_cfg_i,
  output logic              active_o,
  output logic              write_o,
  output logic              mid_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o,
  output bank_cfg_t         cfg_o
);

  logic              active_q, active_d;
  logic              wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  bank_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0]  len;
  logic              accept, last;

  assign len    = (wr_q ? CNT_W'(WR_BASE) : CNT_W'(RD_BASE)) + CNT_W'(cfg_q.waits);
  assign last   = active_q && (cnt_q == len - CNT_W'(1));
  assign accept = req_valid_i && !active_q;

  always_comb begin
    active_d = active_q;
    wr_d     = wr_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    cfg_d    = cfg_q;
    if (accept) begin
      active_d = 1'b1;
      wr_d     = req_write_i;
      cnt_d    = '0;
      addr_d   = req_addr_i;
      cfg_d    = sel_cfg_i;
    end else if (last) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q) begin
      cnt_d    = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      cfg_q    <= '0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
      cnt_q    <= cnt_d;
      addr_q   <= addr_d;
      cfg_q    <= cfg_d;
    end
  end

  assign active_o = active_q;
  assign write_o  = wr_q;
  assign mid_o    = active_q && (cnt_q != '0) && !last;
  assign last_o   = last;
  assign addr_o   = addr_q;
  assign cfg_o    = cfg_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !last_o);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !last_o) |=> (active_o && $stable(addr_o)));

endmodule

// File: rtl/qbc_pin_drv.sv
module qbc_pin_drv
  import qbc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned NUM_CS     = 3,
  parameter int unsigned NUM_STROBE = 2,
  parameter int unsigned FORCE_CS   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active_i,
  input  logic                  write_i,
  input  logic                  mid_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  bank_cfg_t             cfg_i,
  input  logic                  cs_force_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [NUM_CS-1:0]     cs_n_o,
  output logic [NUM_STROBE-1:0] oe_n_o,
  output logic [NUM_STROBE-1:0] we_n_o
);

  logic [ADDR_W-1:0] flip;

  assign flip       = {cfg_i.inv_top, cfg_i.inv_next, {(ADDR_W-2){1'b0}}};
  assign mem_addr_o = active_i ? (addr_i ^ flip) : '0;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic hit;
    if (i == FORCE_CS) begin : g_forced
      assign hit = (active_i && cfg_i.cs_sel == 2'(i)) || cs_force_i;
    end else begin : g_plain
      assign hit = active_i && cfg_i.cs_sel == 2'(i);
    end
    assign cs_n_o[i] = !hit;
  end

  for (genvar p = 0; p < NUM_STROBE; p++) begin : g_strobe
    logic pick;
    assign pick      = active_i && (cfg_i.strobe_sel == 1'(p));
    assign oe_n_o[p] = !(pick && !write_i);
    assign we_n_o[p] = !(pick && write_i && mid_i && !cfg_i.wr_block);
  end

  // R4 R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((~oe_n_o != '0) && (~we_n_o != '0)));

  // R5
  we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~we_n_o != '0) |-> $stable(mem_addr_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> ((&oe_n_o) && (&we_n_o) && (mem_addr_o == '0)));

  // R2
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_force_i |-> $onehot0(~cs_n_o));

endmodule

// File: rtl/quad_bank_ctrl.sv
module quad_bank_ctrl
  import qbc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned NUM_Q      = 4,
  parameter int unsigned NUM_CS     = 3,
  parameter int unsigned NUM_STROBE = 2,
  parameter int unsigned RD_BASE    = 2,
  parameter int unsigned WR_BASE    = 3,
  localparam int unsigned IDX_W     = $clog2(NUM_Q)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic                  cs1_force,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [NUM_CS-1:0]     mem_cs_n,
  output logic [NUM_STROBE-1:0] mem_oe_n,
  output logic [NUM_STROBE-1:0] mem_we_n,
  output logic                  done
);

  bank_cfg_t         bank_cfg [NUM_Q];
  bank_cfg_t         sel_cfg, run_cfg;
  logic [IDX_W-1:0]  quad;
  logic              active, is_wr, mid;
  logic [ADDR_W-1:0] run_addr;

  // The quadrant comes from the untouched request address.
  assign quad    = req_addr[ADDR_W-1 -: IDX_W];
  assign sel_cfg = bank_cfg[quad];

  qbc_bank_regs #(.NUM_Q(NUM_Q)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_we),
    .wr_idx_i  (cfg_idx),
    .wr_data_i (cfg_wdata),
    .cfg_o     (bank_cfg)
  );

  qbc_cycle_seq #(
    .ADDR_W (ADDR_W), .RD_BASE (RD_BASE), .WR_BASE (WR_BASE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .sel_cfg_i   (sel_cfg),
    .active_o    (active),
    .write_o     (is_wr),
    .mid_o       (mid),
    .last_o      (done),
    .addr_o      (run_addr),
    .cfg_o       (run_cfg)
  );

  qbc_pin_drv #(
    .ADDR_W (ADDR_W), .NUM_CS (NUM_CS), .NUM_STROBE (NUM_STROBE), .FORCE_CS (1)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .write_i    (is_wr),
    .mid_i      (mid),
    .addr_i     (run_addr),
    .cfg_i      (run_cfg),
    .cs_force_i (cs1_force),
    .mem_addr_o (mem_addr),
    .cs_n_o     (mem_cs_n),
    .oe_n_o     (mem_oe_n),
    .we_n_o     (mem_we_n)
  );

  // R9
  cs1_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs1_force |-> !mem_cs_n[1]);

endmodule

// File: tb/tb_quad_bank_ctrl.sv
`timescale 1ns/1ps
module tb_quad_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic        cs1_force;
  logic        req_valid, req_write;
  logic [19:0] req_addr;
  logic [19:0] mem_addr;
  logic [2:0]  mem_cs_n;
  logic [1:0]  mem_oe_n, mem_we_n;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  quad_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cs1_force(cs1_force), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .done(done)
  );

  // {write, setting, address}
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'h00, 20'h01234},  // q0 read, cs0, pair0, no wait
    {1'b1, 8'h01, 20'h45678},  // q1 write, cs1
    {1'b0, 8'h46, 20'h8ABCD},  // q2 read, 1 wait, cs2, pair1
    {1'b1, 8'hC4, 20'hC0F0F},  // q3 write, 3 waits, pair1
    {1'b0, 8'h30, 20'h00010},  // q0 read, invert A19 and A18
    {1'b1, 8'h10, 20'h40000},  // q1 write, invert A18 only
    {1'b1, 8'h49, 20'h80001},  // q2 write, 1 wait, inhibited, cs1
    {1'b0, 8'h83, 20'hFFFFF},  // q3 read, 2 waits, no chip select
    {1'b1, 8'h22, 20'h3FFFF}   // q0 write, cs2, invert A19
  };

  function automatic logic [26:0] expect_pins(input logic [7:0] c, input logic [19:0] a,
                                              input logic w, input int k, input logic f);
    logic [19:0] ea;
    logic [2:0]  cs;
    logic [1:0]  oe, we;
    int          len;
    len = (w ? 3 : 2) + int'(c[7:6]);
    ea  = a ^ {c[5], c[4], 18'h0};
    cs  = 3'b111;
    if (c[1:0] != 2'd3) cs[c[1:0]] = 1'b0;
    if (f) cs[1] = 1'b0;
    oe = 2'b11;
    we = 2'b11;
    if (!w) oe[c[2]] = 1'b0;
    if (w && !c[3] && k > 0 && k < len - 1) we[c[2]] = 1'b0;
    return {ea, cs, oe, we};
  endfunction

  task automatic check(input logic [27:0] act, input logic [27:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] q, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = q; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one access and check every clock plus the idle clock after it.
  task automatic access(input logic [7:0] c, input logic [19:0] a, input logic w,
                        input string tag);
    int len;
    len = (w ? 3 : 2) + int'(c[7:6]);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      check({mem_addr, mem_cs_n, mem_oe_n, mem_we_n, done},
            {expect_pins(c, a, w, k, cs1_force), (k == len - 1)},
            $sformatf("%s phase %0d", tag, k));
    end
    @(negedge clk);
    check({mem_addr, mem_cs_n, mem_oe_n, mem_we_n, done},
          {20'h0, {1'b1, !cs1_force, 1'b1}, 2'b11, 2'b11, 1'b0},
          $sformatf("%s idle after cycle (R10)", tag));
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    cs1_force = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle pins after reset
    check({mem_addr, mem_cs_n, mem_oe_n, mem_we_n, done},
          {20'h0, 3'b111, 2'b11, 2'b11, 1'b0}, "R8 reset pins");
    // R8: settings are zero, so q2 reads as cs0, pair0, 2 clocks
    access(8'h00, 20'h9_0000, 1'b0, "R8 cleared setting");

    // Table: the own quadrant gets the setting, the others its complement (R1 R11)
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  c;
      logic [19:0] a;
      logic        w;
      {w, c, a} = VEC[v];
      for (int q = 0; q < 4; q++)
        write_cfg(2'(q), (2'(q) == a[19:18]) ? c : ~c);
      access(c, a, w, $sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", v));
    end

    // R11: a write to q2 leaves q1 alone
    write_cfg(2'd1, 8'h02);
    write_cfg(2'd2, 8'h01);
    access(8'h02, 20'h5_5555, 1'b0, "R11 q1 kept");

    // R6: inhibited write on pair0 keeps cs0 and 4 clocks
    write_cfg(2'd3, 8'h48);
    access(8'h48, 20'hF_0000, 1'b1, "R6 inhibit");

    // R9: forced chip select 1 in idle and during a cs0 access
    cs1_force = 1'b1;
    @(negedge clk);
    check({29'h0, mem_cs_n}, {29'h0, 3'b101}, "R9 idle forced");
    write_cfg(2'd0, 8'h00);
    access(8'h00, 20'h0_0ABC, 1'b0, "R9 forced during access");
    cs1_force = 1'b0;

    // R10: a request changed mid-cycle is ignored
    write_cfg(2'd0, 8'h40);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h0_1111;
    @(negedge clk);
    req_addr = 20'hC_2222; req_write = 1'b1;
    @(negedge clk);
    check({mem_addr, mem_cs_n, mem_oe_n, mem_we_n, done},
          {20'h0_1111, 3'b110, 2'b10, 2'b11, 1'b0}, "R10 ignore mid-cycle request");
    req_valid = 1'b0;
    @(negedge clk);
    check({27'h0, done}, {27'h0, 1'b1}, "R10 done on third clock");
    @(negedge clk);
    check({27'h0, done}, {27'h0, 1'b0}, "R10 done single clock");
    repeat (2) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule